// File: doc/BRIEF.md
# Bus Ownership Release Arbiter

This block holds the bus-ownership state of the default bus master. Other masters that want the bus pull one shared active-low request line. The block answers with an active-low grant, which promises that the bus will be given up when the current bus cycle ends. At that boundary the block drops an own-bus enable, and the strobe drivers use that enable to stop driving. A read-modify-write sequence is never split. While a lock flag is high, no cycle end inside it counts as a release point.

Two handover protocols are supported, and a static input selects one. It may only change while reset is held. In the 2-wire protocol, the other master's ownership ends when it removes its request. In the 3-wire protocol, the new master confirms that it has taken over by pulling an active-low acknowledge. Grant is then withdrawn, and the block waits for the acknowledge to return high before it takes the bus back. Request and acknowledge each pass through a two-flop synchronizer, so any change on these lines acts on the third rising clock edge after it is applied.

Top module: `bus_release_arb`

## Requirements
- R1: While reset is low, and on the first edge after it, grant_n is 1 and own_en is 1.
- R2: A low on req_n sampled before edge k gives grant_n = 0 from edge k+2 onward (the two synchronizer edges plus one state edge). own_en stays 1 at that point, whether or not a bus cycle is in progress.
- R3: With grant pending, own_en falls on the first edge where locked is 0 and either cyc_end is 1 or cyc_active is 0. While a cycle runs without cyc_end, own_en stays 1.
- R4: While locked is 1, no edge releases the bus, including edges with cyc_end at 1. Release happens on the first qualifying edge after locked returns to 0.
- R5: If req_n returns high while grant is pending and the bus has not yet been released, grant_n returns to 1 and own_en stays 1, again with three-edge latency.
- R6: In 2-wire mode (three_wire = 0), after release, grant_n returns to 1 and own_en to 1 on the third edge after req_n goes high.
- R7: In 2-wire mode, ack_n has no effect on either output, whether the block owns the bus or has released it.
- R8: In 3-wire mode (three_wire = 1), after release, a low on ack_n gives grant_n = 1 with own_en held at 0 on the third edge after the low is applied.
- R9: In 3-wire mode, while ack_n is low, removing the request does not restore ownership. own_en returns to 1 on the third edge after ack_n goes high, provided no request is pending.
- R10: In 3-wire mode, if ack_n returns high while req_n is still low, grant_n goes back to 0 and own_en stays 0 until the request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| three_wire | input | 1 | Protocol select: 1 = acknowledge handover, 0 = request-removal handover. Static outside reset |
| req_n | input | 1 | Combined active-low bus request from other masters (asynchronous) |
| ack_n | input | 1 | Active-low acknowledge from the new master (asynchronous, 3-wire only) |
| cyc_active | input | 1 | A bus cycle of this master is in progress |
| cyc_end | input | 1 | One-clock pulse on the final clock of a bus cycle |
| locked | input | 1 | A locked read-modify-write sequence is in progress, held high through its last cycle end |
| grant_n | output | 1 | Active-low bus grant |
| own_en | output | 1 | This master may drive the bus strobes |

## Verification
Some properties are checked on every clock by the assertions. own_en may only fall after grant was asserted and outside a locked sequence. It never falls while locked is high. In 2-wire mode, own_en off always comes with grant asserted. Ownership is only retaken when the synchronized request, and in 3-wire mode the synchronized acknowledge, are both negated. An acknowledge seen while the bus is released withdraws grant on the next edge. Exact latencies need the bench's scenarios: the three-edge response to request, withdrawal and acknowledge, the release edge at a cycle end versus an idle bus, the one-cycle delay after a locked pair ends, and the regrant when acknowledge clears while a request is still pending.

// File: rtl/bra_pkg.sv
// Shared types for the bus ownership release arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package bra_pkg;
    // Ownership state of the default master
    typedef enum logic [1:0] {
        ST_OWN  = 2'd0,  // owns bus, no grant
        ST_PEND = 2'd1,  // grant given, still driving until a boundary
        ST_REL  = 2'd2,  // bus released, grant asserted
        ST_ACKD = 2'd3   // 3-wire: new master acknowledged, grant withdrawn
    } arb_state_e;

    localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/bra_sync.sv
// Multi-bit flop-chain synchronizer for asynchronous control inputs.
// Assumes: each bit is an independent level signal; bits are not
// sampled as a coherent word. Reset loads RST_VAL (the negated level).
module bra_sync #(
    parameter int unsigned    WIDTH   = 2,
    parameter int unsigned    STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stg;
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg;
            // Shift the input through the chain, oldest at the top
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bra_boundary.sv
// Decides whether the current clock is a point where the bus may be
// handed over: the end of an unlocked cycle, or an idle unlocked bus.
// Assumes: locked stays high through the final cycle end of a locked
// read-modify-write pair, and cyc_end is one clock wide.
module bra_boundary (
    input  logic cyc_active,
    input  logic cyc_end,
    input  logic locked,
    output logic release_ok
);
    logic at_edge;

    // A cycle edge is either its final clock or no cycle at all
    always_comb begin
        at_edge = cyc_end || !cyc_active;
    end

    // Never split a locked sequence
    always_comb begin
        release_ok = at_edge && !locked;
    end
endmodule

// File: rtl/bra_fsm.sv
// Ownership state machine. Walks own -> pending -> released, and in
// 3-wire mode on to acknowledged, then back to own.
// Assumes: req_seen and ack_seen are synchronized and active high;
// three_wire only changes under reset. Outputs decode from state only.
module bra_fsm
    import bra_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic three_wire,
    input  logic req_seen,
    input  logic ack_seen,
    input  logic release_ok,
    output logic grant_n,
    output logic own_en
);
    arb_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OWN: begin
                if (req_seen) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (!req_seen)       state_d = ST_OWN;
                else if (release_ok) state_d = ST_REL;
            end
            ST_REL: begin
                if (three_wire && ack_seen) state_d = ST_ACKD;
                else if (!req_seen)         state_d = ST_OWN;
            end
            ST_ACKD: begin
                if (!ack_seen) state_d = req_seen ? ST_REL : ST_OWN;
            end
            default: state_d = ST_OWN;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OWN;
        else        state_q <= state_d;
    end

    // Output decode: grant while pending or released, drive while own or pending
    always_comb begin
        grant_n = !((state_q == ST_PEND) || (state_q == ST_REL));
        own_en  =  (state_q == ST_OWN)  || (state_q == ST_PEND);
    end

    // R8
    ack_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (three_wire && state_q == ST_REL && ack_seen) |=> (grant_n && !own_en));
endmodule

// File: rtl/bus_release_arb.sv
// Bus ownership release arbiter for the default bus master.
// Synchronizes request and acknowledge, qualifies handover points, and
// runs the ownership state machine.
// Assumes: req_n and ack_n are asynchronous; cyc_active, cyc_end, locked
// and three_wire are in the clk domain; three_wire is static outside reset.
module bus_release_arb
    import bra_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic three_wire,
    input  logic req_n,
    input  logic ack_n,
    input  logic cyc_active,
    input  logic cyc_end,
    input  logic locked,
    output logic grant_n,
    output logic own_en
);
    localparam int unsigned NSIG = 2;

    logic [NSIG-1:0] raw_n, sync_n;
    logic            req_seen, ack_seen, release_ok;

    // Bundle the asynchronous active-low inputs
    always_comb begin
        raw_n = {ack_n, req_n};
    end

    bra_sync #(
        .WIDTH  (NSIG),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NSIG{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_n),
        .q    (sync_n)
    );

    // Convert synchronized levels to active-high
    always_comb begin
        req_seen = !sync_n[0];
        ack_seen = !sync_n[1];
    end

    bra_boundary u_bound (
        .cyc_active(cyc_active),
        .cyc_end   (cyc_end),
        .locked    (locked),
        .release_ok(release_ok)
    );

    bra_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .three_wire(three_wire),
        .req_seen  (req_seen),
        .ack_seen  (ack_seen),
        .release_ok(release_ok),
        .grant_n   (grant_n),
        .own_en    (own_en)
    );

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (grant_n && own_en));

    // R3
    own_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_en) |-> (!$past(grant_n) && !$past(locked)));

    // R4
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_en && locked) |=> own_en);

    // R7
    two_wire_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!three_wire && !own_en) |-> !grant_n);

    // R9
    resume_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_en) |-> (!$past(req_seen) && (!three_wire || !$past(ack_seen))));
endmodule

// File: tb/bus_release_arb_tb.sv
// Scoreboard bench: the driver pushes expected output pairs tagged with
// the cycle they are due; the monitor compares them at the falling edge.
module bus_release_arb_tb;
    logic clk = 1'b0;
    logic rst_n, three_wire, req_n, ack_n, cyc_active, cyc_end, locked;
    logic grant_n, own_en;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    when;
        bit    g;
        bit    o;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bus_release_arb u_dut (
        .clk(clk), .rst_n(rst_n), .three_wire(three_wire),
        .req_n(req_n), .ack_n(ack_n), .cyc_active(cyc_active),
        .cyc_end(cyc_end), .locked(locked),
        .grant_n(grant_n), .own_en(own_en)
    );

    // Queue an expectation dly cycles after the current one
    task automatic expect_at(input int dly, input bit g, input bit o, input string tag);
        exp_t e;
        e.when = cyc + dly;
        e.g = g;
        e.o = o;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due items away from the rising edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].when <= cyc) begin
            n_chk++;
            if (sb[0].when != cyc || grant_n !== sb[0].g || own_en !== sb[0].o) begin
                n_fail++;
                $display("FAIL %s: got grant_n=%0b own_en=%0b expected %0b %0b (cycle %0d)",
                         sb[0].tag, grant_n, own_en, sb[0].g, sb[0].o, cyc);
            end
            void'(sb.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0; three_wire = 1'b0; req_n = 1'b1; ack_n = 1'b1;
        cyc_active = 1'b0; cyc_end = 1'b0; locked = 1'b0;
        wait_n(2);
        expect_at(1, 1, 1, "R1 in reset");
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
        expect_at(1, 1, 1, "R1 after reset");
        wait_n(2);

        // Idle bus request, release and resume (R2, R3, R6)
        req_n = 1'b0;
        expect_at(2, 1, 1, "R2 before sync");
        expect_at(3, 0, 1, "R2 grant idle");
        expect_at(4, 0, 0, "R3 release idle");
        wait_n(6);
        req_n = 1'b1;
        expect_at(2, 0, 0, "R6 still released");
        expect_at(3, 1, 1, "R6 resume");
        wait_n(5);

        // Request during a running cycle (R2, R3)
        cyc_active = 1'b1;
        req_n = 1'b0;
        expect_at(3, 0, 1, "R2 grant mid cycle");
        expect_at(7, 0, 1, "R3 hold while cycle runs");
        wait_n(8);
        cyc_end = 1'b1;
        expect_at(1, 0, 0, "R3 release at cycle end");
        wait_n(1);
        cyc_end = 1'b0; cyc_active = 1'b0;
        wait_n(3);
        req_n = 1'b1;
        expect_at(3, 1, 1, "R6 resume after cycle");
        wait_n(5);

        // Locked read-modify-write pair (R4)
        cyc_active = 1'b1; locked = 1'b1;
        req_n = 1'b0;
        expect_at(3, 0, 1, "R4 grant in lock");
        wait_n(5);
        cyc_end = 1'b1;
        expect_at(1, 0, 1, "R4 read end no release");
        wait_n(1);
        cyc_end = 1'b0;
        wait_n(3);
        cyc_end = 1'b1;
        expect_at(1, 0, 1, "R4 write end still locked");
        wait_n(1);
        cyc_end = 1'b0; cyc_active = 1'b0; locked = 1'b0;
        expect_at(1, 0, 0, "R4 release after lock");
        wait_n(3);
        req_n = 1'b1;
        expect_at(3, 1, 1, "R6 resume after lock");
        wait_n(5);

        // Withdrawal before release (R5)
        cyc_active = 1'b1;
        req_n = 1'b0;
        expect_at(3, 0, 1, "R5 pending");
        wait_n(4);
        req_n = 1'b1;
        expect_at(2, 0, 1, "R5 not yet withdrawn");
        expect_at(3, 1, 1, "R5 withdrawn keeps bus");
        wait_n(3);
        cyc_end = 1'b1;
        expect_at(1, 1, 1, "R5 cycle end after withdrawal");
        wait_n(1);
        cyc_end = 1'b0; cyc_active = 1'b0;
        wait_n(3);

        // Acknowledge ignored in 2-wire mode (R7)
        ack_n = 1'b0;
        expect_at(4, 1, 1, "R7 ack alone");
        wait_n(5);
        req_n = 1'b0;
        expect_at(3, 0, 1, "R7 grant with ack low");
        expect_at(4, 0, 0, "R7 release with ack low");
        expect_at(8, 0, 0, "R7 no handover on ack");
        wait_n(10);
        req_n = 1'b1;
        expect_at(3, 1, 1, "R7 resume despite ack low");
        wait_n(4);
        ack_n = 1'b1;
        wait_n(3);

        // Switch to 3-wire under reset
        rst_n = 1'b0; three_wire = 1'b1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);

        // Acknowledge handover and resume (R8, R9)
        req_n = 1'b0;
        expect_at(3, 0, 1, "R2 grant 3-wire");
        expect_at(4, 0, 0, "R3 release 3-wire");
        wait_n(6);
        ack_n = 1'b0;
        expect_at(2, 0, 0, "R8 before ack sync");
        expect_at(3, 1, 0, "R8 grant off on ack");
        wait_n(5);
        req_n = 1'b1;
        expect_at(4, 1, 0, "R9 request drop alone");
        wait_n(6);
        ack_n = 1'b1;
        expect_at(2, 1, 0, "R9 before ack clears");
        expect_at(3, 1, 1, "R9 resume");
        wait_n(5);

        // Acknowledge clears while request still pending (R10)
        req_n = 1'b0;
        expect_at(4, 0, 0, "R10 released");
        wait_n(6);
        ack_n = 1'b0;
        expect_at(3, 1, 0, "R8 acked again");
        wait_n(5);
        ack_n = 1'b1;
        expect_at(3, 0, 0, "R10 regrant");
        wait_n(5);
        req_n = 1'b1;
        expect_at(3, 1, 1, "R10 resume");
        wait_n(6);

        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule